// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This receiver turns a serial PCM stream into parallel signed samples. A bit clock and a word clock frame the data. Both are sampled in the receiver's own system clock domain, and data bits are taken on rising bit-clock edges. In the four stereo framings, three data pins each carry one stereo pair. The three lanes are deserialized side by side and strobe together. In the two packed framings, pin 0 alone carries six channels in fixed slots, and each slot strobes its own lane.

The framing code and the word-length code are static inputs. They may only change while the block is held in reset. Samples are 16, 20 or 24 bits, MSB first, in two's complement. Every sample leaves as a 24-bit value sign-extended from its width, together with a per-lane strobe and a flag that marks the right channel.

Top module: `pcm_frame_rx`

## Requirements
- R1: Framing code 000 (I2S): word clock low carries the left channel, and a word's MSB arrives on the second rising bit-clock edge after a word-clock transition.
- R2: Framing code 011 (left-justified): word clock high carries the left channel, and the MSB arrives on the first rising bit-clock edge after a transition.
- R3: Framing code 001 (right-justified, 32 bit clocks per half frame): word clock high carries the left channel, and the LSB is the last bit before the next transition, so the MSB arrives 32 minus the width edges after a transition.
- R4: Framing code 010 (DSP): only a rising word-clock edge starts a frame. The left MSB is taken on the first rising bit-clock edge that sees the word clock high, and the right word follows right after the left LSB.
- R5: Framing code 100 (packed, 256 bit clocks per frame): pin 0 carries 32-clock slots. Slot k (k = 0..2) of each half carries lane k, with its MSB one clock into the slot. The half with word clock high is left.
- R6: Framing code 101 (packed, 128 bit clocks per frame): pin 0 carries 20-clock slots. Slot k (k = 0..2) of each half starts its MSB at clock 20k, and word clock low marks the left half. A 24-bit width code yields no strobes in this framing.
- R7: `smp_vld[k]` pulses when a sample completes in lane k, and `smp_right` is 1 for a right-channel sample. In the stereo framings, lane k comes from pin k and all lanes strobe together. In the packed framings, only pin 0 is read and exactly one lane strobes per slot.
- R8: Width code 00 selects 24 bits, 01 selects 20 bits and 10 selects 16 bits. Narrower samples are sign-extended to 24 bits.
- R9: Framing codes 110 and 111 and width code 11 produce no strobes.
- R10: After reset, strobes and sample data are zero, and no strobe occurs before the first word-clock transition.
- R11: A strobe lasts one system-clock cycle, and `smp_data` changes only in a cycle whose strobe is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run at least 4x faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word clock or frame sync |
| sd | input | LANES | Serial data pins |
| fmt | input | 3 | Framing code |
| wlen | input | 2 | Word-length code |
| smp_vld | output | LANES | Per-lane sample strobe |
| smp_right | output | 1 | Strobed samples belong to the right channel |
| smp_data | output | LANES*OW | Per-lane sign-extended samples, lane k at bits k*OW upward |

## Verification
Every framing is swept against every width code over three frames. The first frame sends the most negative value on the left channel and the most positive value on the right channel. This exposes a sign-extension fault or a bit offset by one position at the word boundary. The later frames use arithmetic patterns that differ per lane, per side and per frame, so a lane swap, a left/right swap or a misplaced slot shows up as a wrong value. In the packed framings, pins 1 and 2 are held high, which shows whether the receiver reads only pin 0. The reserved codes and the 24-bit packed-128 case send a full frame of data and expect silence.

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx #(
  parameter int LANES = 3,
  parameter int OW    = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck,
  input  logic                  ws,
  input  logic [LANES-1:0]      sd,
  input  logic [2:0]            fmt,
  input  logic [1:0]            wlen,
  output logic [LANES-1:0]      smp_vld,
  output logic                  smp_right,
  output logic [LANES*OW-1:0]   smp_data
);
  localparam int PW = 9;
  localparam logic [PW-1:0] PSAT = {PW{1'b1}};
  localparam int HALF_ST = 32;
  localparam int SLOT_A  = 32;
  localparam int SLOT_B  = 20;
  localparam int PK_SLOTS = 3;
  localparam logic [2:0] F_I2S = 3'd0, F_RJ = 3'd1, F_DSP = 3'd2, F_LJ = 3'd3,
                         F_PA  = 3'd4, F_PB = 3'd5;

  logic [2:0]       sck_q;
  logic [1:0]       ws_q;
  logic [LANES-1:0] sd_q0, sd_q1;
  logic             ws_prev, seen;
  logic [PW-1:0]    pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0; ws_q <= '0; sd_q0 <= '0; sd_q1 <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      ws_q  <= {ws_q[0], ws};
      sd_q0 <= sd;
      sd_q1 <= sd_q0;
    end
  end

  wire rise = sck_q[1] & ~sck_q[2];
  wire wsn  = ws_q[1];

  logic [PW-1:0] wbits;
  always_comb begin
    case (wlen)
      2'd0:    wbits = PW'(24);
      2'd1:    wbits = PW'(20);
      2'd2:    wbits = PW'(16);
      default: wbits = '0;
    endcase
  end

  wire packed_m = (fmt == F_PA) || (fmt == F_PB);
  wire stereo_m = (fmt <= F_LJ);
  wire cfg_ok   = (wlen != 2'd3) && (fmt <= F_PB) && !(fmt == F_PB && wlen == 2'd0);
  wire lvl_left = !((fmt == F_I2S) || (fmt == F_PB));
  wire ws_edge  = seen & ((fmt == F_DSP) ? (wsn & ~ws_prev) : (wsn ^ ws_prev));
  wire [PW-1:0] cur = ws_edge ? '0 : pos;
  wire side = (fmt == F_DSP) ? (cur >= wbits) : (wsn != lvl_left);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_prev <= 1'b0; seen <= 1'b0; pos <= PSAT;
    end else if (rise) begin
      seen    <= 1'b1;
      ws_prev <= wsn;
      if (ws_edge)          pos <= PW'(1);
      else if (pos != PSAT) pos <= pos + PW'(1);
    end
  end

  logic [LANES-1:0] lastv;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PW-1:0] st;
    logic [OW-1:0] sh, dat_l, nxt;
    logic signed [OW-1:0] al, ext;
    logic [PW-1:0] sha;
    logic vld_l, bitin, inwin, last;

    always_comb begin
      case (fmt)
        F_I2S:   st = PW'(1);
        F_LJ:    st = '0;
        F_RJ:    st = PW'(HALF_ST) - wbits;
        F_DSP:   st = side ? wbits : '0;
        F_PA:    st = PW'(g * SLOT_A + 1);
        F_PB:    st = PW'(g * SLOT_B);
        default: st = '0;
      endcase
    end

    assign bitin = packed_m ? sd_q1[0] : sd_q1[g];
    assign inwin = cfg_ok && !(packed_m && g >= PK_SLOTS)
                   && (cur >= st) && (cur < st + wbits);
    assign last  = inwin && (cur == st + wbits - PW'(1));
    assign nxt   = {sh[OW-2:0], bitin};
    assign sha   = PW'(OW) - wbits;
    assign al    = nxt << sha;
    assign ext   = al >>> sha;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh <= '0; dat_l <= '0; vld_l <= 1'b0;
      end else begin
        vld_l <= rise & last;
        if (rise & inwin) sh <= nxt;
        if (rise & last)  dat_l <= ext;
      end
    end

    assign lastv[g]              = last;
    assign smp_vld[g]            = vld_l;
    assign smp_data[g*OW +: OW]  = dat_l;

    AST_SEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_l && $past(wlen) == 2'd2) |-> (dat_l[OW-1:15] == '0 || dat_l[OW-1:15] == '1)); // R8
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              smp_right <= 1'b0;
    else if (rise && |lastv) smp_right <= side;
  end

  AST_BAD_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_ok) |-> smp_vld == '0); // R9
  AST_STEREO_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stereo_m && smp_vld != '0) |-> smp_vld == '1); // R7
  AST_PACKED_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    packed_m |-> $onehot0(smp_vld)); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld != '0 |=> smp_vld == '0); // R11
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld == '0 |-> $stable(smp_data)); // R11
endmodule

// File: tb/pcm_frame_rx_test.sv
module pcm_frame_rx_test;
  logic clk = 0, rst_n = 0, sck = 0, ws = 0;
  logic [2:0] sd = '0, fmt = '0;
  logic [1:0] wlen = '0;
  logic [2:0] smp_vld;
  logic smp_right;
  logic [71:0] smp_data;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit rec_en = 0;
  int rec_n = 0, hold_err = 0, pulse_err = 0;
  int rec_lane [64];
  int rec_side [64];
  logic [23:0] rec_data [64];
  logic [71:0] prev_data = '0;
  logic [2:0]  prev_vld = '0;

  always #4 clk = ~clk;

  pcm_frame_rx uut (.clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .fmt(fmt), .wlen(wlen), .smp_vld(smp_vld), .smp_right(smp_right),
    .smp_data(smp_data));

  always @(negedge clk) begin
    if (rec_en) begin
      for (int l = 0; l < 3; l++) begin
        if (smp_vld[l]) begin
          if (rec_n < 64) begin
            rec_lane[rec_n] = l;
            rec_side[rec_n] = int'(smp_right);
            rec_data[rec_n] = smp_data[l*24 +: 24];
          end
          rec_n++;
        end
      end
      if (smp_vld == '0 && smp_data != prev_data) hold_err++;
      if (smp_vld != '0 && prev_vld != '0) pulse_err++;
    end
    prev_data = smp_data;
    prev_vld  = smp_vld;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rawv(int f, int ln, int s, int w);
    logic [31:0] r;
    if (f == 0 && s == 0)      r = 32'd1 << (w - 1);
    else if (f == 0)           r = (32'd1 << (w - 1)) - 32'd1;
    else r = 32'(f * 172337 + ln * 20899 + s * 40967 + 42405) ^ 32'h00C3_5A5A;
    return r & ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [23:0] expv(int f, int ln, int s, int w);
    logic signed [31:0] t;
    t = rawv(f, ln, s, w) << (32 - w);
    t = t >>> (32 - w);
    return t[23:0];
  endfunction

  function automatic string tagf(int f);
    case (f)
      0: return "R1";
      3: return "R2";
      1: return "R3";
      2: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic tick(input logic w, input logic [2:0] d);
    @(negedge clk);
    sck = 0; ws = w; sd = d;
    repeat (4) @(negedge clk);
    sck = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cfg(input int f, input int wl, input int nfr);
    int w, total, half, st;
    bit pk, lvl_left, idle_ws, valid;
    logic [2:0] d;
    logic wsv;
    string tg;
    @(negedge clk);
    rst_n = 0; fmt = 3'(f); wlen = 2'(wl); sck = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(smp_vld == '0, "R10", "strobe after reset", 32'(smp_vld), 0);
    chk(smp_data == '0, "R10", "data after reset", smp_data[31:0], 0);
    w = (wl == 1) ? 20 : (wl == 2) ? 16 : 24;
    pk = (f == 4 || f == 5);
    lvl_left = !(f == 0 || f == 5);
    idle_ws = (f == 2) ? 1'b0 : !lvl_left;
    valid = (f <= 5) && (wl != 3) && !(f == 5 && wl == 0);
    total = (f == 4) ? 256 : (f == 5) ? 128 : 64;
    half = total / 2;
    tg = tagf(f);
    if (w < 24 && valid) tg = {tg, " R8"};
    if (!valid) tg = (f == 5) ? "R6 R9" : "R9";
    rec_n = 0; hold_err = 0; pulse_err = 0; rec_en = 1;
    repeat (4) tick(idle_ws, pk ? 3'b110 : 3'b000);
    for (int fr = 0; fr < nfr; fr++) begin
      for (int i = 0; i < total; i++) begin
        int h, p;
        h = i / half; p = i % half;
        wsv = (f == 2) ? (i == 0) : ((h == 0) ? lvl_left : !lvl_left);
        d = pk ? 3'b110 : 3'b000;
        if (f == 0 || f == 1 || f == 3) begin
          st = (f == 0) ? 1 : (f == 3) ? 0 : 32 - w;
          if (p >= st && p < st + w)
            for (int k = 0; k < 3; k++) d[k] = rawv(fr, k, h, w)[w-1-(p-st)];
        end else if (f == 2) begin
          if (i < 2 * w)
            for (int k = 0; k < 3; k++) d[k] = rawv(fr, k, i / w, w)[w-1-(i%w)];
        end else if (pk) begin
          int sl, s, o;
          sl = (f == 4) ? 32 : 20;
          s = p / sl;
          o = (p % sl) - ((f == 4) ? 1 : 0);
          if (s < 3 && o >= 0 && o < w) d[0] = rawv(fr, s, h, w)[w-1-o];
        end else begin
          d = 3'(i) ^ 3'b101;
        end
        tick(wsv, d);
      end
    end
    repeat (4) tick(idle_ws, pk ? 3'b110 : 3'b000);
    repeat (8) @(negedge clk);
    rec_en = 0;
    if (valid) begin
      chk(rec_n == nfr * 6, tg, "sample count", 32'(rec_n), 32'(nfr * 6));
      for (int e = 0; e < nfr * 6 && e < rec_n && e < 64; e++) begin
        int fr2, r, s2, ln;
        fr2 = e / 6; r = e % 6; s2 = r / 3; ln = r % 3;
        chk(rec_lane[e] == ln, "R7", "lane", 32'(rec_lane[e]), 32'(ln));
        chk(rec_side[e] == s2, "R7", "right flag", 32'(rec_side[e]), 32'(s2));
        chk(rec_data[e] == expv(fr2, ln, s2, w), tg, "sample value",
            32'(rec_data[e]), 32'(expv(fr2, ln, s2, w)));
      end
    end else begin
      chk(rec_n == 0, tg, "strobes on rejected config", 32'(rec_n), 0);
    end
    chk(hold_err == 0, "R11", "data moved without strobe", 32'(hold_err), 0);
    chk(pulse_err == 0, "R11", "strobe longer than one cycle", 32'(pulse_err), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired before sweep completed actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int f = 0; f < 6; f++)
      for (int wl = 0; wl < 3; wl++)
        run_cfg(f, wl, 3);
    run_cfg(6, 0, 1);
    run_cfg(7, 1, 1);
    run_cfg(0, 3, 1);
    run_cfg(4, 3, 1);
    finish_run();
  end
endmodule